// File: doc/BRIEF.md
# Sampling Clock Rate Monitor

This block lives in the fast bus-clock domain. It watches a separate, slower and unrelated sampling clock and checks that the sampling clock is fast enough. A sampling clock that runs slower than one sixteenth of the bus clock is a clock fault. The block resynchronises the sampling clock through a flop chain and finds its rising edges in the bus domain. It then counts the bus cycles between consecutive edges and raises a fault when that count runs past the limit. The check runs continuously while the block is enabled.

The result comes out in three forms. A live fault flag follows the condition and drops again once the sampling clock has shown a full healthy period. A sticky status flag catches each new fault episode and holds until software writes a clear. A one-cycle pulse marks the start of each episode. An interrupt output forwards the sticky flag when interrupts are enabled.

Control is a four-state machine:
- OFF: the block is disabled and the counter is held at zero.
- WATCH: the sampling clock is healthy.
- FAULT: the limit was exceeded.
- PROVE: the block has seen one edge after a fault and is timing the next period.

The transitions are:
- start (OFF to WATCH, when enabled).
- overrun (WATCH to FAULT, when the counter expires).
- first_edge (FAULT to PROVE, when an edge is seen).
- relapse (PROVE to FAULT, when the counter expires).
- healed (PROVE to WATCH, when an edge arrives in time).
- shutdown (any state to OFF, when enable drops).

Top module: `smpclk_rate_monitor`

## Requirements
- R1: While reset is asserted and in the first cycle after it, err_live_o, err_sticky_o, err_pulse_o and irq_o are all 0.
- R2: A sampling clock whose rising edges are at most 16 bus cycles apart never raises err_live_o or err_pulse_o. This includes a period of exactly 16.
- R3: A sampling clock whose rising edges are 17 or more bus cycles apart drives err_live_o to 1, and err_live_o stays 1 while that rate persists.
- R4: Take a sampling clock that stops after a rising edge. err_live_o is 0 after the 19th bus-clock rising edge that follows the sampling edge, and 1 after the 20th. This is two synchroniser stages, one edge-detect stage, 16 counted cycles and the state register. When the block is enabled with a stopped sampling clock, err_live_o is 0 after the 17th bus edge and 1 after the 18th.
- R5: Once a fault is present, a single sampling edge does not clear err_live_o. It clears only when a second rising edge follows the first within 16 bus cycles.
- R6: err_pulse_o is high for exactly one cycle, in the same cycle that err_live_o rises from 0. It rises once per fault episode, however long that episode lasts.
- R7: err_sticky_o sets together with err_pulse_o. It stays set through recovery and through disable, and clears one cycle after err_clear_i is sampled high. If a set and a clear fall in the same cycle, the set wins.
- R8: irq_o is 1 exactly when err_sticky_o is 1 and irq_en_i is 1.
- R9: When enable_i is low, the next cycle has err_live_o at 0. Nothing is detected while the block is disabled, whatever the sampling clock does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low reset, bus domain |
| enable_i | input | 1 | Runs the monitor when 1 |
| smp_clk_i | input | 1 | Sampling clock, asynchronous to clk_i |
| err_clear_i | input | 1 | Clears the sticky fault flag |
| irq_en_i | input | 1 | Lets the sticky flag reach irq_o |
| err_live_o | output | 1 | Current clock-fault condition |
| err_sticky_o | output | 1 | Latched fault status |
| err_pulse_o | output | 1 | One-cycle pulse at the start of a fault episode |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench drives sampling periods of exactly 16 and exactly 17 bus cycles. An off-by-one in the counter compare would fault the 16-cycle clock or pass the 17-cycle one. It measures the fault latency to the exact bus edge, both after the last sampling edge and after enable. A miscounted synchroniser or counter shows up there as a flag that rises one cycle early or late. After a fault it sends one lone sampling edge to catch a design that clears on the first edge instead of a full good period. It also holds the clear input high across a fault onset; a design that gives clear priority would lose that event. A slow clock is kept running over many periods to expose a pulse that repeats each period rather than once per episode.

// File: rtl/smon_pkg.sv
package smon_pkg;

    // Default limit: allowed bus cycles per sampling period.
    localparam int unsigned SMON_RATIO_DEFAULT = 16;
    // Default depth of the resynchronising flop chain.
    localparam int unsigned SMON_SYNC_DEFAULT  = 2;

    typedef enum logic [1:0] {
        SM_OFF   = 2'd0,
        SM_WATCH = 2'd1,
        SM_FAULT = 2'd2,
        SM_PROVE = 2'd3
    } smon_state_e;

endpackage

// File: rtl/smon_edge_sync.sv
module smon_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o
);

    logic last_q;
    logic synced_w;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            logic stage_q;
            if (g == 0) begin : g_first
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) stage_q <= 1'b0;
                    else         stage_q <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) stage_q <= 1'b0;
                    else         stage_q <= g_stage[g-1].stage_q;
                end
            end
        end
    endgenerate

    assign synced_w = g_stage[STAGES-1].stage_q;

    // One extra flop remembers the previous synchronised level
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) last_q <= 1'b0;
        else         last_q <= synced_w;
    end

    assign rise_o = synced_w & ~last_q;

endmodule

// File: rtl/smon_period_counter.sv
module smon_period_counter #(
    parameter int unsigned LIMIT = 16,
    parameter int unsigned CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          hold_i,
    input  logic          restart_i,
    output logic [CW-1:0] count_o,
    output logic          expired_o
);

    localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT);

    logic [CW-1:0] count_q;

    // Counts bus cycles since the last sampling edge and saturates at the limit
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            count_q <= '0;
        end else if (hold_i || restart_i) begin
            count_q <= '0;
        end else if (count_q < LIMIT_C) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count_o   = count_q;
    assign expired_o = (count_q >= LIMIT_C);

endmodule

// File: rtl/smon_fsm.sv
module smon_fsm
    import smon_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        enable_i,
    input  logic        rise_i,
    input  logic        expired_i,
    input  logic        clear_i,
    output smon_state_e state_o,
    output logic        hold_o,
    output logic        live_o,
    output logic        pulse_o,
    output logic        sticky_o
);

    smon_state_e state_q;
    smon_state_e state_d;
    logic        onset_w;
    logic        pulse_q;
    logic        sticky_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!enable_i) begin
            state_d = SM_OFF;                                  // shutdown
        end else begin
            unique case (state_q)
                SM_OFF:   state_d = SM_WATCH;                  // start
                SM_WATCH: if (expired_i) state_d = SM_FAULT;   // overrun
                SM_FAULT: if (rise_i)    state_d = SM_PROVE;   // first_edge
                SM_PROVE: begin
                    if (expired_i)   state_d = SM_FAULT;       // relapse
                    else if (rise_i) state_d = SM_WATCH;       // healed
                end
                default:  state_d = SM_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= SM_OFF;
        else         state_q <= state_d;
    end

    // A new episode starts only when a healthy state is left for FAULT
    assign onset_w = (state_q == SM_WATCH) && (state_d == SM_FAULT);

    // Output register: the pulse and the sticky flag, where a set beats a clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pulse_q  <= 1'b0;
            sticky_q <= 1'b0;
        end else begin
            pulse_q <= onset_w;
            if (onset_w)      sticky_q <= 1'b1;
            else if (clear_i) sticky_q <= 1'b0;
        end
    end

    assign state_o  = state_q;
    assign hold_o   = (state_q == SM_OFF);
    assign live_o   = (state_q == SM_FAULT) || (state_q == SM_PROVE);
    assign pulse_o  = pulse_q;
    assign sticky_o = sticky_q;

endmodule

// File: rtl/smpclk_rate_monitor.sv
module smpclk_rate_monitor
    import smon_pkg::*;
#(
    parameter int unsigned RATIO_LIMIT = SMON_RATIO_DEFAULT,
    parameter int unsigned SYNC_STAGES = SMON_SYNC_DEFAULT
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic enable_i,
    input  logic smp_clk_i,
    input  logic err_clear_i,
    input  logic irq_en_i,
    output logic err_live_o,
    output logic err_sticky_o,
    output logic err_pulse_o,
    output logic irq_o
);

    localparam int unsigned CNT_W = $clog2(RATIO_LIMIT + 1);

    logic              rise_w;
    logic              hold_w;
    logic              expired_w;
    logic [CNT_W-1:0]  cnt_w;
    smon_state_e       state_w;
    logic              sticky_w;

    smon_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (smp_clk_i),
        .rise_o  (rise_w)
    );

    smon_period_counter #(
        .LIMIT (RATIO_LIMIT),
        .CW    (CNT_W)
    ) u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .hold_i    (hold_w),
        .restart_i (rise_w),
        .count_o   (cnt_w),
        .expired_o (expired_w)
    );

    smon_fsm u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .enable_i  (enable_i),
        .rise_i    (rise_w),
        .expired_i (expired_w),
        .clear_i   (err_clear_i),
        .state_o   (state_w),
        .hold_o    (hold_w),
        .live_o    (err_live_o),
        .pulse_o   (err_pulse_o),
        .sticky_o  (sticky_w)
    );

    assign err_sticky_o = sticky_w;
    assign irq_o        = sticky_w & irq_en_i;

endmodule

// File: rtl/smon_checker.sv
module smon_checker #(
    parameter int unsigned LIMIT = 16,
    parameter int unsigned CW    = $clog2(LIMIT + 1)
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          enable_i,
    input logic          err_clear_i,
    input logic          irq_en_i,
    input logic          err_live_o,
    input logic          err_sticky_o,
    input logic          err_pulse_o,
    input logic          irq_o,
    input logic          edge_rise,
    input logic [CW-1:0] cnt
);

    // R6
    pulse_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_pulse_o |=> !err_pulse_o);

    // R6
    pulse_with_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_pulse_o |-> err_live_o);

    // R6
    live_rise_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(err_live_o) |-> err_pulse_o);

    // R7
    sticky_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_pulse_o |-> err_sticky_o);

    // R7
    sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_sticky_o && !err_clear_i) |=> err_sticky_o);

    // R8
    irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_en_i |-> !irq_o);

    // R9
    off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> !err_live_o);

    // R3
    count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt <= CW'(LIMIT));

    // R4
    edge_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_rise |=> (cnt == '0));

endmodule

bind smpclk_rate_monitor smon_checker #(
    .LIMIT (RATIO_LIMIT),
    .CW    (CNT_W)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enable_i     (enable_i),
    .err_clear_i  (err_clear_i),
    .irq_en_i     (irq_en_i),
    .err_live_o   (err_live_o),
    .err_sticky_o (err_sticky_o),
    .err_pulse_o  (err_pulse_o),
    .irq_o        (irq_o),
    .edge_rise    (rise_w),
    .cnt          (cnt_w)
);

// File: tb/smpclk_rate_monitor_tb_top.sv
`timescale 1ns/1ps
module smpclk_rate_monitor_tb_top;

    logic clk = 1'b0;
    logic rst_n;
    logic enable;
    logic smp_clk;
    logic err_clear;
    logic irq_en;
    logic err_live;
    logic err_sticky;
    logic err_pulse;
    logic irq;

    int checks    = 0;
    int failures  = 0;
    int smp_period = 0;
    bit shot_req  = 1'b0;
    int pulse_cnt = 0;
    bit done      = 1'b0;

    always #2.5 clk = ~clk;

    smpclk_rate_monitor dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .enable_i     (enable),
        .smp_clk_i    (smp_clk),
        .err_clear_i  (err_clear),
        .irq_en_i     (irq_en),
        .err_live_o   (err_live),
        .err_sticky_o (err_sticky),
        .err_pulse_o  (err_pulse),
        .irq_o        (irq)
    );

    always @(negedge clk) if (err_pulse) pulse_cnt++;

    // Sampling clock source, stepped on bus-clock falling edges
    initial begin
        smp_clk = 1'b0;
        forever begin
            if (smp_period == 0) begin
                smp_clk = 1'b0;
                if (shot_req) begin
                    shot_req = 1'b0;
                    smp_clk  = 1'b1;
                    repeat (2) @(negedge clk);
                    smp_clk  = 1'b0;
                end else begin
                    @(negedge clk);
                end
            end else begin
                int p;
                p = smp_period;
                smp_clk = 1'b1;
                repeat (p / 2) @(negedge clk);
                smp_clk = 1'b0;
                repeat (p - p / 2) @(negedge clk);
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic count_live(input int n, output int highs, output int lows);
        highs = 0;
        lows  = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (err_live) highs++; else lows++;
        end
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        check(err_live == 0 && err_sticky == 0, "R1", "live/sticky in reset",
              {err_live, err_sticky}, 0);
        check(err_pulse == 0 && irq == 0, "R1", "pulse/irq in reset",
              {err_pulse, irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(err_live == 0 && err_sticky == 0 && err_pulse == 0 && irq == 0,
              "R1", "outputs after reset", {err_live, err_sticky, err_pulse, irq}, 0);
    endtask

    task automatic t_fast();
        int hi, lo;
        smp_period = 4;
        enable = 1'b1;
        repeat (60) @(negedge clk);
        pulse_cnt = 0;
        smp_period = 8;
        count_live(200, hi, lo);
        check(hi == 0, "R2", "live high cycles at period 8", hi, 0);
        smp_period = 16;
        count_live(300, hi, lo);
        check(hi == 0, "R2", "live high cycles at period 16", hi, 0);
        check(pulse_cnt == 0, "R2", "pulses with healthy clock", pulse_cnt, 0);
    endtask

    task automatic t_slow();
        int hi, lo;
        pulse_cnt = 0;
        smp_period = 17;
        repeat (200) @(negedge clk);
        check(err_live == 1, "R3", "live at period 17", err_live, 1);
        count_live(100, hi, lo);
        check(lo == 0, "R3", "live low cycles while slow", lo, 0);
        check(pulse_cnt == 1, "R6", "pulses in one slow episode", pulse_cnt, 1);
        check(err_sticky == 1, "R7", "sticky after fault", err_sticky, 1);
    endtask

    task automatic t_recover();
        int hi, lo;
        smp_period = 0;
        repeat (60) @(negedge clk);
        check(err_live == 1, "R5", "live with stopped clock", err_live, 1);
        shot_req = 1'b1;
        count_live(60, hi, lo);
        check(lo == 0, "R5", "live low cycles after one lone edge", lo, 0);
        smp_period = 8;
        repeat (60) @(negedge clk);
        check(err_live == 0, "R5", "live after healthy periods", err_live, 0);
        check(err_sticky == 1, "R7", "sticky kept through recovery", err_sticky, 1);
    endtask

    task automatic t_irq();
        irq_en = 1'b0;
        @(negedge clk);
        check(irq == 0, "R8", "irq with enable off", irq, 0);
        irq_en = 1'b1;
        #1;
        check(irq == 1, "R8", "irq with enable on and sticky set", irq, 1);
        @(negedge clk);
        err_clear = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;
        check(err_sticky == 0, "R7", "sticky after clear", err_sticky, 0);
        check(irq == 0, "R8", "irq after clear", irq, 0);
    endtask

    task automatic t_stop_latency();
        err_clear = 1'b1;
        @(posedge smp_clk);
        smp_period = 0;
        repeat (19) @(posedge clk);
        @(negedge clk);
        check(err_live == 0, "R4", "live after 19 edges", err_live, 0);
        @(posedge clk);
        @(negedge clk);
        check(err_live == 1, "R4", "live after 20 edges", err_live, 1);
        check(err_pulse == 1, "R6", "pulse on onset", err_pulse, 1);
        check(err_sticky == 1, "R7", "set wins over held clear", err_sticky, 1);
        @(negedge clk);
        check(err_pulse == 0, "R6", "pulse one cycle", err_pulse, 0);
        check(err_sticky == 0, "R7", "held clear takes effect", err_sticky, 0);
        err_clear = 1'b0;
    endtask

    task automatic t_disable();
        int hi, lo;
        enable = 1'b0;
        @(negedge clk);
        check(err_live == 0, "R9", "live one cycle after disable", err_live, 0);
        pulse_cnt = 0;
        smp_period = 23;
        count_live(100, hi, lo);
        check(hi == 0 && pulse_cnt == 0, "R9", "detections while disabled",
              hi + pulse_cnt, 0);
        check(err_sticky == 0, "R9", "sticky untouched while disabled", err_sticky, 0);
        smp_period = 0;
        repeat (40) @(negedge clk);
    endtask

    task automatic t_enable_latency();
        enable = 1'b1;
        repeat (17) @(posedge clk);
        @(negedge clk);
        check(err_live == 0, "R4", "live 17 edges after enable", err_live, 0);
        @(posedge clk);
        @(negedge clk);
        check(err_live == 1, "R4", "live 18 edges after enable", err_live, 1);
    endtask

    initial begin
        rst_n     = 1'b0;
        enable    = 1'b0;
        err_clear = 1'b0;
        irq_en    = 1'b0;
        t_reset();
        t_fast();
        t_slow();
        t_recover();
        t_irq();
        t_stop_latency();
        t_disable();
        t_enable_latency();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule